// File: doc/BRIEF.md
# Immediate Constant Load Generator

This block turns a load-immediate operation and its raw immediate field into the 64-bit value that an execute stage writes back to a register. A four-bit operation select picks one of twelve placement forms. There are short forms with zero or one fill. There are forms that place a ten-bit field at bit 16, bit 22 or bit 54. There are sixteen-bit forms with zero or one fill. There are forms that take a 33-bit signed field, sign-extend it, and then shift it by 0, 16 or 32 places. The last form passes a whole 64-bit immediate through unchanged.

An extended-mode flag widens the two short forms from ten to twelve immediate bits. Immediate bits above the field that the chosen form uses are ignored. A select value outside the defined set raises an illegal-operation flag and gives an all-zero result.

The decode and placement logic is purely combinational. An output stage follows it. With the default configuration this stage is a one-cycle register with a valid bit, run by a two-state machine. The state EMPTY moves to LOADED when an input is valid, LOADED stays in LOADED when a new input is valid, and LOADED returns to EMPTY when no input is valid. If the stage is configured away, the result is passed straight through.

Top module: `imm_const_gen`

## Requirements
- R1: Op 0 (short zero-fill) gives imm[9:0] with zeros above it. With ext=1 it gives imm[11:0] with zeros above it.
- R2: Op 1 (short one-fill) gives imm[9:0] with every higher bit set to one. With ext=1 it gives imm[11:0] with every higher bit set to one.
- R3: Op 2 puts imm[9:0] at bits 25:16 with zeros in bits 63:26. Op 3 does the same but sets bits 63:26 to one. For both ops, bits 15:0 are zero.
- R4: Op 4 puts imm[9:0] at bits 31:22. Op 5 puts imm[9:0] at bits 63:54. Every other bit is zero for both ops.
- R5: Op 6 gives imm[15:0] with zeros above it. Op 7 gives imm[15:0] with ones above it.
- R6: Op 8 sign-extends imm[32:0] from bit 32. Op 9 shifts that sign-extended value left by 16. Op 10 shifts it left by 32. Bits shifted past bit 63 are discarded, and the sign always comes from imm[32].
- R7: Op 11 gives imm[63:0] unchanged.
- R8: Ops 12 to 15 give out_illegal=1 and out_value=0. Ops 0 to 11 give out_illegal=0.
- R9: Immediate bits above the field that the selected op uses have no effect on the result.
- R10: The ext input affects only ops 0 and 1.
- R11: A result appears with out_valid=1 on the cycle after the one in which it was presented with in_valid=1. On the cycle after in_valid=0, out_valid is 0 and out_value and out_illegal keep their previous values.
- R12: While rst_n is low, and after it is released, out_valid, out_illegal and out_value are all zero until the first valid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 4 | Placement form select |
| in_ext | input | 1 | Extended mode: widens the short forms to 12 bits |
| in_imm | input | 64 | Raw immediate field |
| out_valid | output | 1 | Result valid |
| out_value | output | 64 | Constant to write back |
| out_illegal | output | 1 | Undefined operation select |

## Verification
The bench sweeps every select value with both settings of ext, over set patterns, every walking-one position and pseudo-random words. This finds a field width that is off by one, a fill taken from the wrong bit, or an unused high immediate bit that leaks into the result. The 33-bit shifted forms are driven with bit 32 set and with it clear. A design that took the sign after shifting, or kept bits that should have overflowed, would give a wrong upper word. After each result, a cycle with no valid input checks that the output register holds its value and drops valid. Illegal selects are checked for a zero result, so a design that leaves stale data on the output is caught.

// File: rtl/immgen_pkg.sv
package immgen_pkg;

    localparam int CTL_WIDTH_BITS = 7;
    localparam int CTL_SHIFT_BITS = 6;

    typedef enum logic [3:0] {
        OP_SHORT_ZX = 4'd0,
        OP_SHORT_OX = 4'd1,
        OP_MID_ZX   = 4'd2,
        OP_MID_OX   = 4'd3,
        OP_HIGH     = 4'd4,
        OP_QHIGH    = 4'd5,
        OP_HALF_ZX  = 4'd6,
        OP_HALF_OX  = 4'd7,
        OP_PFX_SX   = 4'd8,
        OP_PFX_SX16 = 4'd9,
        OP_PFX_SX32 = 4'd10,
        OP_FULL     = 4'd11
    } ld_op_e;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_ONE  = 2'd1,
        FILL_SIGN = 2'd2
    } fill_e;

    typedef struct packed {
        logic                      legal;
        fill_e                     fill;
        logic [CTL_WIDTH_BITS-1:0] width;
        logic [CTL_SHIFT_BITS-1:0] shift;
    } place_t;

    typedef enum logic {
        OS_EMPTY  = 1'b0,
        OS_LOADED = 1'b1
    } out_state_e;

endpackage

// File: rtl/imm_decode.sv
module imm_decode
    import immgen_pkg::*;
#(
    parameter int DATA_W      = 64,
    parameter int SHORT_W     = 10,
    parameter int SHORT_EXT_W = 12,
    parameter int MID_SHIFT   = 16,
    parameter int HI_SHIFT    = 22,
    parameter int QHI_SHIFT   = 54,
    parameter int HALF_W      = 16,
    parameter int PFX_W       = 33,
    parameter int PFX_SHIFT_A = 16,
    parameter int PFX_SHIFT_B = 32
) (
    input  logic [3:0] op,
    input  logic       ext,
    output place_t     ctl
);

    localparam logic [CTL_WIDTH_BITS-1:0] W_SHORT  = CTL_WIDTH_BITS'(SHORT_W);
    localparam logic [CTL_WIDTH_BITS-1:0] W_SHORTX = CTL_WIDTH_BITS'(SHORT_EXT_W);
    localparam logic [CTL_WIDTH_BITS-1:0] W_HALF   = CTL_WIDTH_BITS'(HALF_W);
    localparam logic [CTL_WIDTH_BITS-1:0] W_PFX    = CTL_WIDTH_BITS'(PFX_W);
    localparam logic [CTL_WIDTH_BITS-1:0] W_FULL   = CTL_WIDTH_BITS'(DATA_W);
    localparam logic [CTL_SHIFT_BITS-1:0] S_NONE   = '0;
    localparam logic [CTL_SHIFT_BITS-1:0] S_MID    = CTL_SHIFT_BITS'(MID_SHIFT);
    localparam logic [CTL_SHIFT_BITS-1:0] S_HI     = CTL_SHIFT_BITS'(HI_SHIFT);
    localparam logic [CTL_SHIFT_BITS-1:0] S_QHI    = CTL_SHIFT_BITS'(QHI_SHIFT);
    localparam logic [CTL_SHIFT_BITS-1:0] S_PFXA   = CTL_SHIFT_BITS'(PFX_SHIFT_A);
    localparam logic [CTL_SHIFT_BITS-1:0] S_PFXB   = CTL_SHIFT_BITS'(PFX_SHIFT_B);

    logic [CTL_WIDTH_BITS-1:0] short_width;

    always_comb begin
        short_width = ext ? W_SHORTX : W_SHORT;
    end

    always_comb begin
        ctl = '{legal: 1'b1, fill: FILL_ZERO, width: W_SHORT, shift: S_NONE};
        case (op)
            OP_SHORT_ZX: ctl = '{legal: 1'b1, fill: FILL_ZERO, width: short_width, shift: S_NONE};
            OP_SHORT_OX: ctl = '{legal: 1'b1, fill: FILL_ONE,  width: short_width, shift: S_NONE};
            OP_MID_ZX:   ctl = '{legal: 1'b1, fill: FILL_ZERO, width: W_SHORT,     shift: S_MID};
            OP_MID_OX:   ctl = '{legal: 1'b1, fill: FILL_ONE,  width: W_SHORT,     shift: S_MID};
            OP_HIGH:     ctl = '{legal: 1'b1, fill: FILL_ZERO, width: W_SHORT,     shift: S_HI};
            OP_QHIGH:    ctl = '{legal: 1'b1, fill: FILL_ZERO, width: W_SHORT,     shift: S_QHI};
            OP_HALF_ZX:  ctl = '{legal: 1'b1, fill: FILL_ZERO, width: W_HALF,      shift: S_NONE};
            OP_HALF_OX:  ctl = '{legal: 1'b1, fill: FILL_ONE,  width: W_HALF,      shift: S_NONE};
            OP_PFX_SX:   ctl = '{legal: 1'b1, fill: FILL_SIGN, width: W_PFX,       shift: S_NONE};
            OP_PFX_SX16: ctl = '{legal: 1'b1, fill: FILL_SIGN, width: W_PFX,       shift: S_PFXA};
            OP_PFX_SX32: ctl = '{legal: 1'b1, fill: FILL_SIGN, width: W_PFX,       shift: S_PFXB};
            OP_FULL:     ctl = '{legal: 1'b1, fill: FILL_ZERO, width: W_FULL,      shift: S_NONE};
            default:     ctl = '{legal: 1'b0, fill: FILL_ZERO, width: W_SHORT,     shift: S_NONE};
        endcase
    end

endmodule

// File: rtl/imm_place.sv
module imm_place
    import immgen_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] imm,
    input  place_t            ctl,
    output logic [DATA_W-1:0] value
);

    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    logic [DATA_W-1:0] field_mask;
    logic [DATA_W-1:0] top_aligned;
    logic              sign_bit;
    logic              fill_bit;
    logic [DATA_W-1:0] extended;

    always_comb begin
        if (int'(ctl.width) >= DATA_W) begin
            field_mask = ALL_ONES;
        end else begin
            field_mask = ~(ALL_ONES << ctl.width);
        end
    end

    always_comb begin
        top_aligned = imm >> (ctl.width - CTL_WIDTH_BITS'(1));
        sign_bit    = top_aligned[0];
    end

    always_comb begin
        case (ctl.fill)
            FILL_ONE:  fill_bit = 1'b1;
            FILL_SIGN: fill_bit = sign_bit;
            default:   fill_bit = 1'b0;
        endcase
    end

    always_comb begin
        extended = (imm & field_mask) | (fill_bit ? ~field_mask : '0);
        value    = ctl.legal ? (extended << ctl.shift) : '0;
    end

endmodule

// File: rtl/imm_outreg.sv
module imm_outreg
    import immgen_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter bit REGISTERED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_value,
    input  logic              in_illegal,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_value,
    output logic              out_illegal
);

    generate
        if (REGISTERED) begin : g_reg
            out_state_e        state_q;
            out_state_e        state_d;
            logic [DATA_W-1:0] value_q;
            logic              illegal_q;

            always_comb begin
                state_d = state_q;
                unique case (state_q)
                    OS_EMPTY:  state_d = in_valid ? OS_LOADED : OS_EMPTY;
                    OS_LOADED: state_d = in_valid ? OS_LOADED : OS_EMPTY;
                    default:   state_d = OS_EMPTY;
                endcase
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    state_q <= OS_EMPTY;
                end else begin
                    state_q <= state_d;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    value_q   <= '0;
                    illegal_q <= 1'b0;
                end else if (in_valid) begin
                    value_q   <= in_value;
                    illegal_q <= in_illegal;
                end
            end

            assign out_valid   = (state_q == OS_LOADED);
            assign out_value   = value_q;
            assign out_illegal = illegal_q;

            AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid); // R11
            AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid); // R11
            AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> ($stable(out_value) && $stable(out_illegal))); // R11
        end else begin : g_pass
            assign out_valid   = in_valid;
            assign out_value   = in_value;
            assign out_illegal = in_illegal;
        end
    endgenerate

endmodule

// File: rtl/imm_const_gen.sv
module imm_const_gen
    import immgen_pkg::*;
#(
    parameter int DATA_W      = 64,
    parameter int SHORT_W     = 10,
    parameter int SHORT_EXT_W = 12,
    parameter int MID_SHIFT   = 16,
    parameter int HI_SHIFT    = 22,
    parameter int QHI_SHIFT   = 54,
    parameter int HALF_W      = 16,
    parameter int PFX_W       = 33,
    parameter int PFX_SHIFT_A = 16,
    parameter int PFX_SHIFT_B = 32,
    parameter bit REGISTERED  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        in_op,
    input  logic              in_ext,
    input  logic [DATA_W-1:0] in_imm,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_value,
    output logic              out_illegal
);

    place_t            ctl;
    logic [DATA_W-1:0] placed;

    imm_decode #(
        .DATA_W      (DATA_W),
        .SHORT_W     (SHORT_W),
        .SHORT_EXT_W (SHORT_EXT_W),
        .MID_SHIFT   (MID_SHIFT),
        .HI_SHIFT    (HI_SHIFT),
        .QHI_SHIFT   (QHI_SHIFT),
        .HALF_W      (HALF_W),
        .PFX_W       (PFX_W),
        .PFX_SHIFT_A (PFX_SHIFT_A),
        .PFX_SHIFT_B (PFX_SHIFT_B)
    ) u_decode (
        .op  (in_op),
        .ext (in_ext),
        .ctl (ctl)
    );

    imm_place #(
        .DATA_W (DATA_W)
    ) u_place (
        .imm   (in_imm),
        .ctl   (ctl),
        .value (placed)
    );

    imm_outreg #(
        .DATA_W     (DATA_W),
        .REGISTERED (REGISTERED)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_value    (placed),
        .in_illegal  (!ctl.legal),
        .out_valid   (out_valid),
        .out_value   (out_value),
        .out_illegal (out_illegal)
    );

    localparam logic [DATA_W-1:0] MID_LOW_MASK = ~({DATA_W{1'b1}} << MID_SHIFT);
    localparam logic [DATA_W-1:0] QHI_LOW_MASK = ~({DATA_W{1'b1}} << QHI_SHIFT);

    generate
        if (REGISTERED) begin : g_chk
            AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && out_illegal) |-> (out_value == '0)); // R8
            AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_op > OP_FULL) |=> out_illegal); // R8
            AST_MID_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && (in_op == OP_MID_ZX || in_op == OP_MID_OX))
                |=> ((out_value & MID_LOW_MASK) == '0)); // R3
            AST_QHIGH_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_op == OP_QHIGH) |=> ((out_value & QHI_LOW_MASK) == '0)); // R4
            AST_FULL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_op == OP_FULL) |=> (out_value == $past(in_imm))); // R7
        end
    endgenerate

endmodule

// File: tb/imm_const_gen_test.sv
module imm_const_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic        in_ext = 1'b0;
    logic [63:0] in_imm = '0;
    logic        out_valid;
    logic [63:0] out_value;
    logic        out_illegal;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    imm_const_gen uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_ext(in_ext), .in_imm(in_imm), .out_valid(out_valid),
        .out_value(out_value), .out_illegal(out_illegal)
    );

    function automatic logic [63:0] model(input logic [3:0] op, input logic ext,
                                          input logic [63:0] x);
        logic s;
        s = x[32];
        case (op)
            4'd0:  model = ext ? {52'b0, x[11:0]} : {54'b0, x[9:0]};
            4'd1:  model = ext ? {{52{1'b1}}, x[11:0]} : {{54{1'b1}}, x[9:0]};
            4'd2:  model = {38'b0, x[9:0], 16'b0};
            4'd3:  model = {{38{1'b1}}, x[9:0], 16'b0};
            4'd4:  model = {32'b0, x[9:0], 22'b0};
            4'd5:  model = {x[9:0], 54'b0};
            4'd6:  model = {48'b0, x[15:0]};
            4'd7:  model = {{48{1'b1}}, x[15:0]};
            4'd8:  model = {{31{s}}, x[32:0]};
            4'd9:  model = {{15{s}}, x[32:0], 16'b0};
            4'd10: model = {x[31:0], 32'b0};
            4'd11: model = x;
            default: model = 64'b0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0: tag_of = "R1";
            4'd1: tag_of = "R2";
            4'd2, 4'd3: tag_of = "R3";
            4'd4, 4'd5: tag_of = "R4";
            4'd6, 4'd7: tag_of = "R5";
            4'd8, 4'd9, 4'd10: tag_of = "R6";
            4'd11: tag_of = "R7";
            default: tag_of = "R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [3:0] op, input logic ext,
                         input logic [63:0] x);
        logic [63:0] held;
        logic        held_ill;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_ext = ext; in_imm = x;
        @(negedge clk);
        check(tag, out_value, model(op, ext, x));
        check("R8", {63'b0, out_illegal}, {63'b0, (op > 4'd11)});
        check("R11", {63'b0, out_valid}, 64'd1);
        held = out_value; held_ill = out_illegal;
        in_valid = 1'b0; in_op = ~op; in_ext = ~ext; in_imm = ~x;
        @(negedge clk);
        check("R11", {63'b0, out_valid}, 64'd0);
        check("R11", {out_value[62:0], out_illegal}, {held[62:0], held_ill});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] lfsr;
        repeat (3) @(negedge clk);
        check("R12", {out_value[62:0], out_valid}, 64'd0);
        check("R12", {63'b0, out_illegal}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", {out_value[62:0], out_valid}, 64'd0);
        check("R12", {63'b0, out_illegal}, 64'd0);

        for (int op = 0; op < 16; op++) begin
            for (int e = 0; e < 2; e++) begin
                apply(tag_of(4'(op)), 4'(op), e[0], 64'h0);
                apply(tag_of(4'(op)), 4'(op), e[0], '1);
                apply(tag_of(4'(op)), 4'(op), e[0], 64'h5555_5555_5555_5555);
                apply(tag_of(4'(op)), 4'(op), e[0], 64'hAAAA_AAAA_AAAA_AAAA);
                for (int b = 0; b < 64; b++) begin
                    apply(tag_of(4'(op)), 4'(op), e[0], 64'd1 << b);
                end
                lfsr = 64'hC0FF_EE12_3456_789B ^ (64'(op) << 8) ^ 64'(e);
                for (int k = 0; k < 24; k++) begin
                    lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
                    apply(tag_of(4'(op)), 4'(op), e[0], lfsr);
                end
            end
        end

        // R6 sign boundaries: bit 32 set with zero below, and clear with ones below
        apply("R6", 4'd9, 1'b0, 64'h0000_0001_0000_0000);
        apply("R6", 4'd10, 1'b0, 64'h0000_0001_8000_0001);
        apply("R6", 4'd8, 1'b0, 64'h0000_0000_FFFF_FFFF);
        // R9 unused high bits set, field clear
        apply("R9", 4'd4, 1'b0, 64'hFFFF_FFFF_FFFF_FC00);
        apply("R9", 4'd0, 1'b1, 64'hFFFF_FFFF_FFFF_F000);
        apply("R9", 4'd8, 1'b0, 64'hFFFF_FFFE_0000_0000);
        // R10 ext has no effect on non-short ops
        apply("R10", 4'd2, 1'b1, 64'h0000_0000_0000_0C00);
        apply("R10", 4'd7, 1'b1, 64'h0000_0000_0001_8000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule